// File: doc/BRIEF.md
# E1 Per-Second Performance Monitor

This block turns one-second snapshots from an E1 framer into line performance data. A pulse on the tick input, one clock cycle wide, marks the end of each second. In that same cycle the block samples the line conditions of that second (signal loss, carrier loss, all-ones, timeslot-16 all-ones, far-end alarms, slip, and loss of frame and multiframe sync) and the framer's error counts (bipolar violations, frame alignment errors, CRC-4 errors and E-bit errors). Every second it is allowed to evaluate, it builds an alarm status word. It also files the second into the counters of the current interval, using the usual telecom rules. An unavailable second blocks every other classification. Severe-error thresholds decide whether a second counts as bursty and whether it feeds degraded-minute accounting.

At the end of each interval (900 evaluated seconds by default), the current counters are added into saturating running totals. They are also pushed into a history of the most recent intervals (48 by default), and then cleared. A combinational read port returns the status word, any current counter, any total or any history field. A read in the same cycle as an update returns the values from before the update.

Top module: `e1_perf_mon`

## Requirements
- R1: After reset, every readable location returns zero. This covers the status word, the current counters, the totals and the history.
- R2: The first SKIP_TICKS ticks after reset change nothing. Evaluation starts with the tick that follows them.
- R3: On each evaluated tick the status word is reloaded. Its bits are: bit0 signal or carrier loss, bit1 all-ones, bit2 timeslot-16 all-ones (only with CAS on), bit3 far-end multiframe alarm (only with CAS on), bit4 far-end frame alarm, bit5 frame sync loss, bit6 multiframe sync loss (CAS multiframe loss with CAS on, or CRC multiframe loss with CRC-4 on). When none of these bits is set, the word reads 0x80.
- R4: Field indices are 0 BPV, 1 FAS, 2 CRC, 3 EBIT, 4 UAS, 5 LES, 6 ES, 7 BES, 8 SES, 9 OOFS, 10 CSS, 11 DM. The BPV and FAS fields add the snapshot counts on every evaluated tick. The CRC and EBIT fields add their counts only when CRC-4 mode is on. All current fields are 16 bits wide and saturate at 65535. The path code violation count (PCV) of a second is the FAS count, plus the CRC count when CRC-4 mode is on.
- R5: A second with all-ones, carrier loss or signal loss is unavailable. It adds one to UAS and leaves LES, ES, BES, SES, OOFS and the degraded-minute accumulators unchanged.
- R6: In an available second, LES adds one when BPV is nonzero. ES adds one when PCV is nonzero, sync is lost or a slip occurred. OOFS adds one when sync is lost. Sync lost means frame sync loss, or multiframe sync loss under the same gating as status bit6.
- R7: An available second counts as SES when BPV ≥ 2048 or PCV ≥ 832. Otherwise it counts as BES when PCV > 1, and it adds one second, and BPV+PCV errors, to the degraded-minute accumulators. SES and BES never both advance on the same tick.
- R8: On every SECS_PER_MIN-th evaluated tick, DM adds one if errors×1000 > seconds×2048, where both values include the current tick. Both accumulators are then cleared.
- R9: Any slip adds one to CSS, whether or not the second is available.
- R10: On the SECS_PER_INTERVAL-th evaluated tick of an interval, the current fields (including that tick) are added into 32-bit saturating totals. History entry 0 takes those fields and each older entry moves down by one. The current fields are then cleared.
- R11: Reading address 0 returns the status. Address 1+f returns current field f, address 13+f returns total f, and address 25+12·e+f returns history entry e field f. Any other address returns zero.
- R12: Without a tick, the status and the counters keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickIn | input | 1 | One-cycle pulse marking the end of a second |
| crc4En | input | 1 | CRC-4 mode enable |
| casEn | input | 1 | CAS signalling mode enable |
| sigLoss | input | 1 | Signal loss during the second |
| carrierLoss | input | 1 | Carrier loss during the second |
| allOnes | input | 1 | Unframed all-ones received |
| ts16AllOnes | input | 1 | Timeslot 16 all-ones received |
| farMfAlarm | input | 1 | Far-end multiframe alarm |
| farFrameAlarm | input | 1 | Far-end frame alarm |
| slipEvt | input | 1 | Slip occurred during the second |
| frameSyncLoss | input | 1 | Frame alignment lost |
| casMfSyncLoss | input | 1 | CAS multiframe alignment lost |
| crcMfSyncLoss | input | 1 | CRC-4 multiframe alignment lost |
| bpvCount | input | ERR_W | Bipolar violations in the second |
| fasCount | input | ERR_W | Frame alignment errors in the second |
| crcCount | input | ERR_W | CRC-4 errors in the second |
| ebitCount | input | ERR_W | E-bit errors in the second |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | TOT_W | Read data, zero-extended |

## Verification
The bench first drives a handful of targeted seconds. These sit on the two severe-error thresholds (one below and one at each), toggle CRC-4 mode with a CRC count present, combine slip with all-ones, and put CAS-gated alarms against the mode bits. Each of these separates one classification rule from its neighbours. A long sweep then walks every condition input and the mode bits through coprime periods. It also cycles the error counts through zero, one, the threshold edges and large values, so the fields saturate. Because the sweep spans many short intervals, it exercises history overflow and degraded-minute decisions on both sides of the threshold. After every tick, every readable location is compared with a model that the bench computes arithmetically.

// File: rtl/e1pm_pkg.sv
package e1pm_pkg;
  localparam int NFIELD = 12;

  localparam int F_BPV  = 0;
  localparam int F_FAS  = 1;
  localparam int F_CRC  = 2;
  localparam int F_EBIT = 3;
  localparam int F_UAS  = 4;
  localparam int F_LES  = 5;
  localparam int F_ES   = 6;
  localparam int F_BES  = 7;
  localparam int F_SES  = 8;
  localparam int F_OOFS = 9;
  localparam int F_CSS  = 10;
  localparam int F_DM   = 11;

  localparam int ST_LOS   = 0;
  localparam int ST_AIS   = 1;
  localparam int ST_AIS16 = 2;
  localparam int ST_FARMF = 3;
  localparam int ST_FARFR = 4;
  localparam int ST_LOF   = 5;
  localparam int ST_LOMF  = 6;
  localparam logic [7:0] STATUS_CLEAR = 8'h80;

  typedef struct packed {
    logic evalSec;
    logic minuteEnd;
    logic intervalEnd;
  } pmStrobe_t;

  typedef struct packed {
    logic sigLoss;
    logic carrierLoss;
    logic allOnes;
    logic ts16AllOnes;
    logic farMfAlarm;
    logic farFrameAlarm;
    logic slipEvt;
    logic frameSyncLoss;
    logic casMfSyncLoss;
    logic crcMfSyncLoss;
  } pmCond_t;
endpackage

// File: rtl/e1pm_ctrl.sv
module e1pm_ctrl
  import e1pm_pkg::*;
#(
  parameter int SKIP_TICKS        = 1,
  parameter int SECS_PER_MIN      = 60,
  parameter int SECS_PER_INTERVAL = 900
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickIn,
  output pmStrobe_t strobe
);
  localparam int SKIP_W = $clog2(SKIP_TICKS + 2);
  localparam int MIN_W  = $clog2(SECS_PER_MIN + 1);
  localparam int SEC_W  = $clog2(SECS_PER_INTERVAL + 1);

  logic [SKIP_W-1:0] skipCnt;
  logic [MIN_W-1:0]  minCnt;
  logic [SEC_W-1:0]  secCnt;
  logic              skipDone;

  assign skipDone           = (skipCnt == SKIP_W'(SKIP_TICKS));
  assign strobe.evalSec     = tickIn && skipDone;
  assign strobe.minuteEnd   = strobe.evalSec && (minCnt == MIN_W'(SECS_PER_MIN - 1));
  assign strobe.intervalEnd = strobe.evalSec && (secCnt == SEC_W'(SECS_PER_INTERVAL - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skipCnt <= '0;
      minCnt  <= '0;
      secCnt  <= '0;
    end else begin
      if (tickIn && !skipDone) skipCnt <= skipCnt + 1'b1;
      if (strobe.evalSec) begin
        minCnt <= strobe.minuteEnd   ? '0 : minCnt + 1'b1;
        secCnt <= strobe.intervalEnd ? '0 : secCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/e1pm_datapath.sv
module e1pm_datapath
  import e1pm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TOT_W      = 32,
  parameter int ERR_W      = 16,
  parameter int HIST_DEPTH = 48,
  parameter int SES_BPV    = 2048,
  parameter int SES_PCV    = 832,
  parameter int DM_NUM     = 2048,
  parameter int DM_DEN     = 1000,
  parameter int ACC_W      = 32
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  pmStrobe_t                                   strobe,
  input  pmCond_t                                     cond,
  input  logic                                        crc4En,
  input  logic                                        casEn,
  input  logic [ERR_W-1:0]                            bpvCount,
  input  logic [ERR_W-1:0]                            fasCount,
  input  logic [ERR_W-1:0]                            crcCount,
  input  logic [ERR_W-1:0]                            ebitCount,
  output logic [7:0]                                  statusWord,
  output logic [NFIELD-1:0][CNT_W-1:0]                curCnt,
  output logic [NFIELD-1:0][TOT_W-1:0]                totCnt,
  output logic [HIST_DEPTH-1:0][NFIELD-1:0][CNT_W-1:0] histCnt
);
  localparam int INC_W  = ERR_W + 1;
  localparam int CSUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
  localparam int TSUM_W = TOT_W + 1;
  localparam int PROD_W = 2 * ACC_W;

  function automatic logic [CNT_W-1:0] satCnt(input logic [CNT_W-1:0] a,
                                              input logic [INC_W-1:0] b);
    logic [CSUM_W-1:0] s;
    s = CSUM_W'(a) + CSUM_W'(b);
    if (s > CSUM_W'({CNT_W{1'b1}})) return {CNT_W{1'b1}};
    return CNT_W'(s);
  endfunction

  function automatic logic [TOT_W-1:0] satTot(input logic [TOT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    logic [TSUM_W-1:0] s;
    s = TSUM_W'(a) + TSUM_W'(b);
    if (s[TOT_W]) return {TOT_W{1'b1}};
    return s[TOT_W-1:0];
  endfunction

  logic [INC_W-1:0]              pcv;
  logic                          lineDown;
  logic                          oofSec;
  logic                          mfLoss;
  logic                          sesSec;
  logic                          degQual;
  logic                          dmHit;
  logic [7:0]                    statusRaw;
  logic [7:0]                    statusNext;
  logic [ACC_W-1:0]              degSec, degErr, degSecNext, degErrNext;
  logic [NFIELD-1:0][INC_W-1:0]  incAmt;
  logic [NFIELD-1:0][CNT_W-1:0]  curNext;

  always_comb begin
    pcv      = INC_W'(fasCount) + (crc4En ? INC_W'(crcCount) : INC_W'(0));
    lineDown = cond.allOnes | cond.carrierLoss | cond.sigLoss;
    mfLoss   = (casEn & cond.casMfSyncLoss) | (crc4En & cond.crcMfSyncLoss);
    oofSec   = cond.frameSyncLoss | mfLoss;
    sesSec   = !lineDown && ((int'(bpvCount) >= SES_BPV) || (int'(pcv) >= SES_PCV));
    degQual  = !lineDown && !sesSec;
  end

  always_comb begin
    degSecNext = degSec + ACC_W'(degQual);
    degErrNext = degErr + (degQual ? (ACC_W'(bpvCount) + ACC_W'(pcv)) : ACC_W'(0));
    dmHit      = strobe.minuteEnd &&
                 ((PROD_W'(degErrNext) * PROD_W'(DM_DEN)) > (PROD_W'(degSecNext) * PROD_W'(DM_NUM)));
  end

  always_comb begin
    incAmt         = '0;
    incAmt[F_BPV]  = INC_W'(bpvCount);
    incAmt[F_FAS]  = INC_W'(fasCount);
    incAmt[F_CRC]  = crc4En ? INC_W'(crcCount) : INC_W'(0);
    incAmt[F_EBIT] = crc4En ? INC_W'(ebitCount) : INC_W'(0);
    incAmt[F_UAS]  = INC_W'(lineDown);
    incAmt[F_LES]  = INC_W'(!lineDown && (bpvCount != '0));
    incAmt[F_ES]   = INC_W'(!lineDown && ((pcv != '0) || oofSec || cond.slipEvt));
    incAmt[F_BES]  = INC_W'(degQual && (pcv > INC_W'(1)));
    incAmt[F_SES]  = INC_W'(sesSec);
    incAmt[F_OOFS] = INC_W'(!lineDown && oofSec);
    incAmt[F_CSS]  = INC_W'(cond.slipEvt);
    incAmt[F_DM]   = INC_W'(dmHit);
  end

  genvar gf;
  generate
    for (gf = 0; gf < NFIELD; gf++) begin : g_field
      assign curNext[gf] = satCnt(curCnt[gf], incAmt[gf]);
    end
  endgenerate

  always_comb begin
    statusRaw           = '0;
    statusRaw[ST_LOS]   = cond.sigLoss | cond.carrierLoss;
    statusRaw[ST_AIS]   = cond.allOnes;
    statusRaw[ST_AIS16] = casEn & cond.ts16AllOnes;
    statusRaw[ST_FARMF] = casEn & cond.farMfAlarm;
    statusRaw[ST_FARFR] = cond.farFrameAlarm;
    statusRaw[ST_LOF]   = cond.frameSyncLoss;
    statusRaw[ST_LOMF]  = mfLoss;
    statusNext          = (statusRaw == '0) ? STATUS_CLEAR : statusRaw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusWord <= '0;
      degSec     <= '0;
      degErr     <= '0;
      curCnt     <= '0;
      totCnt     <= '0;
    end else if (strobe.evalSec) begin
      statusWord <= statusNext;
      if (strobe.minuteEnd) begin
        degSec <= '0;
        degErr <= '0;
      end else begin
        degSec <= degSecNext;
        degErr <= degErrNext;
      end
      if (strobe.intervalEnd) begin
        curCnt <= '0;
        for (int f = 0; f < NFIELD; f++) totCnt[f] <= satTot(totCnt[f], curNext[f]);
      end else begin
        curCnt <= curNext;
      end
    end
  end

  genvar ge;
  generate
    for (ge = 0; ge < HIST_DEPTH; ge++) begin : g_hist
      if (ge == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) histCnt[ge] <= '0;
          else if (strobe.evalSec && strobe.intervalEnd) histCnt[ge] <= curNext;
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) histCnt[ge] <= '0;
          else if (strobe.evalSec && strobe.intervalEnd) histCnt[ge] <= histCnt[ge-1];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/e1pm_regread.sv
module e1pm_regread
  import e1pm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TOT_W      = 32,
  parameter int HIST_DEPTH = 48,
  parameter int ADDR_W     = 10
) (
  input  logic [7:0]                                  statusWord,
  input  logic [NFIELD-1:0][CNT_W-1:0]                curCnt,
  input  logic [NFIELD-1:0][TOT_W-1:0]                totCnt,
  input  logic [HIST_DEPTH-1:0][NFIELD-1:0][CNT_W-1:0] histCnt,
  input  logic [ADDR_W-1:0]                           rdAddr,
  output logic [TOT_W-1:0]                            rdData
);
  localparam int CUR_BASE  = 1;
  localparam int TOT_BASE  = CUR_BASE + NFIELD;
  localparam int HIST_BASE = TOT_BASE + NFIELD;

  always_comb begin
    rdData = '0;
    if (rdAddr == '0) rdData = TOT_W'(statusWord);
    for (int f = 0; f < NFIELD; f++) begin
      if (rdAddr == ADDR_W'(CUR_BASE + f)) rdData = TOT_W'(curCnt[f]);
      if (rdAddr == ADDR_W'(TOT_BASE + f)) rdData = totCnt[f];
    end
    for (int e = 0; e < HIST_DEPTH; e++) begin
      for (int f = 0; f < NFIELD; f++) begin
        if (rdAddr == ADDR_W'(HIST_BASE + e * NFIELD + f)) rdData = TOT_W'(histCnt[e][f]);
      end
    end
  end
endmodule

// File: rtl/e1_perf_mon.sv
module e1_perf_mon
  import e1pm_pkg::*;
#(
  parameter int SKIP_TICKS        = 1,
  parameter int SECS_PER_MIN      = 60,
  parameter int SECS_PER_INTERVAL = 900,
  parameter int HIST_DEPTH        = 48,
  parameter int CNT_W             = 16,
  parameter int TOT_W             = 32,
  parameter int ERR_W             = 16,
  parameter int SES_BPV           = 2048,
  parameter int SES_PCV           = 832,
  parameter int ADDR_W            = $clog2(1 + 2 * NFIELD + HIST_DEPTH * NFIELD)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              crc4En,
  input  logic              casEn,
  input  logic              sigLoss,
  input  logic              carrierLoss,
  input  logic              allOnes,
  input  logic              ts16AllOnes,
  input  logic              farMfAlarm,
  input  logic              farFrameAlarm,
  input  logic              slipEvt,
  input  logic              frameSyncLoss,
  input  logic              casMfSyncLoss,
  input  logic              crcMfSyncLoss,
  input  logic [ERR_W-1:0]  bpvCount,
  input  logic [ERR_W-1:0]  fasCount,
  input  logic [ERR_W-1:0]  crcCount,
  input  logic [ERR_W-1:0]  ebitCount,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [TOT_W-1:0]  rdData
);
  pmStrobe_t                                   strobe;
  pmCond_t                                     cond;
  logic [7:0]                                  statusWord;
  logic [NFIELD-1:0][CNT_W-1:0]                curCnt;
  logic [NFIELD-1:0][TOT_W-1:0]                totCnt;
  logic [HIST_DEPTH-1:0][NFIELD-1:0][CNT_W-1:0] histCnt;

  assign cond = '{sigLoss:       sigLoss,
                  carrierLoss:   carrierLoss,
                  allOnes:       allOnes,
                  ts16AllOnes:   ts16AllOnes,
                  farMfAlarm:    farMfAlarm,
                  farFrameAlarm: farFrameAlarm,
                  slipEvt:       slipEvt,
                  frameSyncLoss: frameSyncLoss,
                  casMfSyncLoss: casMfSyncLoss,
                  crcMfSyncLoss: crcMfSyncLoss};

  e1pm_ctrl #(
    .SKIP_TICKS       (SKIP_TICKS),
    .SECS_PER_MIN     (SECS_PER_MIN),
    .SECS_PER_INTERVAL(SECS_PER_INTERVAL)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .tickIn(tickIn),
    .strobe(strobe)
  );

  e1pm_datapath #(
    .CNT_W     (CNT_W),
    .TOT_W     (TOT_W),
    .ERR_W     (ERR_W),
    .HIST_DEPTH(HIST_DEPTH),
    .SES_BPV   (SES_BPV),
    .SES_PCV   (SES_PCV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cond      (cond),
    .crc4En    (crc4En),
    .casEn     (casEn),
    .bpvCount  (bpvCount),
    .fasCount  (fasCount),
    .crcCount  (crcCount),
    .ebitCount (ebitCount),
    .statusWord(statusWord),
    .curCnt    (curCnt),
    .totCnt    (totCnt),
    .histCnt   (histCnt)
  );

  e1pm_regread #(
    .CNT_W     (CNT_W),
    .TOT_W     (TOT_W),
    .HIST_DEPTH(HIST_DEPTH),
    .ADDR_W    (ADDR_W)
  ) u_rd (
    .statusWord(statusWord),
    .curCnt    (curCnt),
    .totCnt    (totCnt),
    .histCnt   (histCnt),
    .rdAddr    (rdAddr),
    .rdData    (rdData)
  );
endmodule

// File: rtl/e1pm_checker.sv
module e1pm_checker
  import e1pm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         evalSec,
  input logic                         intervalEnd,
  input logic                         lineDown,
  input logic                         slipSeen,
  input logic [7:0]                   statusWord,
  input logic [NFIELD-1:0][CNT_W-1:0] curCnt
);
  // R3
  status_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    evalSec |=> (statusWord != 8'h00));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !evalSec |=> ($stable(curCnt) && $stable(statusWord)));

  // R5
  uas_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evalSec && lineDown && !intervalEnd) |=>
      ($stable(curCnt[F_LES]) && $stable(curCnt[F_ES]) && $stable(curCnt[F_BES]) &&
       $stable(curCnt[F_SES]) && $stable(curCnt[F_OOFS])));

  // R10
  roll_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evalSec && intervalEnd) |=> (curCnt == '0));

  // R9
  css_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evalSec && slipSeen && !intervalEnd && (curCnt[F_CSS] != {CNT_W{1'b1}})) |=>
      (curCnt[F_CSS] == $past(curCnt[F_CSS]) + 1'b1));

  // R7
  ses_bes_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evalSec && !intervalEnd) |=>
      !((curCnt[F_SES] != $past(curCnt[F_SES])) && (curCnt[F_BES] != $past(curCnt[F_BES]))));
endmodule

bind e1_perf_mon e1pm_checker #(.CNT_W(CNT_W)) chk (
  .clk        (clk),
  .rstN       (rstN),
  .evalSec    (strobe.evalSec),
  .intervalEnd(strobe.intervalEnd),
  .lineDown   (allOnes | carrierLoss | sigLoss),
  .slipSeen   (slipEvt),
  .statusWord (statusWord),
  .curCnt     (curCnt)
);

// File: tb/e1_perf_mon_test.sv
module e1_perf_mon_test;
  localparam int SKIP = 2;
  localparam int SPM  = 4;
  localparam int SPI  = 8;
  localparam int HD   = 3;
  localparam int NF   = 12;
  localparam int LAST = 2 * NF + HD * NF;
  localparam int AW   = $clog2(1 + 2 * NF + HD * NF);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0;
  logic crc4En = 1'b0, casEn = 1'b0;
  logic sigLoss = 1'b0, carrierLoss = 1'b0, allOnes = 1'b0, ts16AllOnes = 1'b0;
  logic farMfAlarm = 1'b0, farFrameAlarm = 1'b0, slipEvt = 1'b0, frameSyncLoss = 1'b0;
  logic casMfSyncLoss = 1'b0, crcMfSyncLoss = 1'b0;
  logic [15:0] bpvCount = '0, fasCount = '0, crcCount = '0, ebitCount = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [31:0] rdData;

  always #10 clk = ~clk;

  e1_perf_mon #(
    .SKIP_TICKS(SKIP), .SECS_PER_MIN(SPM), .SECS_PER_INTERVAL(SPI), .HIST_DEPTH(HD),
    .CNT_W(16), .TOT_W(32), .ERR_W(16)
  ) uut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .crc4En(crc4En), .casEn(casEn),
    .sigLoss(sigLoss), .carrierLoss(carrierLoss), .allOnes(allOnes), .ts16AllOnes(ts16AllOnes),
    .farMfAlarm(farMfAlarm), .farFrameAlarm(farFrameAlarm), .slipEvt(slipEvt),
    .frameSyncLoss(frameSyncLoss), .casMfSyncLoss(casMfSyncLoss), .crcMfSyncLoss(crcMfSyncLoss),
    .bpvCount(bpvCount), .fasCount(fasCount), .crcCount(crcCount), .ebitCount(ebitCount),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  int vectors = 0;
  int miscompares = 0;

  longint mCur[NF];
  longint mTot[NF];
  longint mHist[HD][NF];
  longint mStatus = 0;
  longint degSec = 0, degErr = 0;
  int skipLeft = SKIP;
  int secCnt = 0, minCnt = 0;

  function automatic longint sat(input longint v, input longint mx);
    return (v > mx) ? mx : v;
  endfunction

  function automatic void bump(input int f, input longint amt);
    mCur[f] = sat(mCur[f] + amt, 65535);
  endfunction

  function automatic void modelStep();
    longint bpv, pcv, st;
    bit down, oof, mfl, ses, qual;
    if (skipLeft > 0) begin
      skipLeft--;
      return;
    end
    bpv  = longint'(bpvCount);
    pcv  = longint'(fasCount) + (crc4En ? longint'(crcCount) : 0);
    down = allOnes || carrierLoss || sigLoss;
    mfl  = (casEn && casMfSyncLoss) || (crc4En && crcMfSyncLoss);
    oof  = frameSyncLoss || mfl;
    ses  = !down && (bpv >= 2048 || pcv >= 832);
    qual = !down && !ses;
    st = 0;
    if (sigLoss || carrierLoss) st |= 1;
    if (allOnes) st |= 2;
    if (casEn && ts16AllOnes) st |= 4;
    if (casEn && farMfAlarm) st |= 8;
    if (farFrameAlarm) st |= 16;
    if (frameSyncLoss) st |= 32;
    if (mfl) st |= 64;
    mStatus = (st == 0) ? 128 : st;
    bump(0, bpv);
    bump(1, longint'(fasCount));
    if (crc4En) begin
      bump(2, longint'(crcCount));
      bump(3, longint'(ebitCount));
    end
    if (down) bump(4, 1);
    if (!down && bpv != 0) bump(5, 1);
    if (!down && (pcv != 0 || oof || slipEvt)) bump(6, 1);
    if (qual && pcv > 1) bump(7, 1);
    if (ses) bump(8, 1);
    if (!down && oof) bump(9, 1);
    if (slipEvt) bump(10, 1);
    if (qual) begin
      degSec += 1;
      degErr += bpv + pcv;
    end
    minCnt++;
    if (minCnt == SPM) begin
      minCnt = 0;
      if (degErr * 1000 > degSec * 2048) bump(11, 1);
      degSec = 0;
      degErr = 0;
    end
    secCnt++;
    if (secCnt == SPI) begin
      secCnt = 0;
      for (int e = HD - 1; e > 0; e--)
        for (int f = 0; f < NF; f++) mHist[e][f] = mHist[e-1][f];
      for (int f = 0; f < NF; f++) begin
        mHist[0][f] = mCur[f];
        mTot[f] = sat(mTot[f] + mCur[f], 64'hFFFF_FFFF);
        mCur[f] = 0;
      end
    end
  endfunction

  function automatic longint expectedAt(input int a);
    if (a == 0) return mStatus;
    if (a <= NF) return mCur[a-1];
    if (a <= 2 * NF) return mTot[a-1-NF];
    if (a <= LAST) return mHist[(a-1-2*NF)/NF][(a-1-2*NF)%NF];
    return 0;
  endfunction

  function automatic string tagAt(input int a);
    int f;
    if (a == 0) return "R3";
    if (a > LAST) return "R11";
    if (a > NF) return "R10";
    f = a - 1;
    if (f <= 3) return "R4";
    if (f == 4) return "R5";
    if (f == 5 || f == 6 || f == 9) return "R6";
    if (f == 7 || f == 8) return "R7";
    if (f == 10) return "R9";
    return "R8";
  endfunction

  task automatic checkAddr(input int a, input string tagOvr);
    longint exp;
    string tag;
    rdAddr = AW'(a);
    #1;
    exp = expectedAt(a);
    tag = (tagOvr == "") ? tagAt(a) : tagOvr;
    vectors++;
    if (longint'(rdData) != exp) begin
      miscompares++;
      $display("FAIL %s addr %0d: actual %0d expected %0d", tag, a, rdData, exp);
    end
  endtask

  task automatic checkAll(input string tagOvr);
    for (int a = 0; a <= LAST; a++) checkAddr(a, tagOvr);
    checkAddr(LAST + 1, "R11");
  endtask

  task automatic pulse(input string tagOvr);
    @(negedge clk);
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
    modelStep();
    checkAll(tagOvr);
  endtask

  task automatic clearInputs();
    {sigLoss, carrierLoss, allOnes, ts16AllOnes, farMfAlarm, farFrameAlarm} = '0;
    {slipEvt, frameSyncLoss, casMfSyncLoss, crcMfSyncLoss, crc4En, casEn} = '0;
    bpvCount = '0; fasCount = '0; crcCount = '0; ebitCount = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog (R12): actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    for (int f = 0; f < NF; f++) begin
      mCur[f] = 0;
      mTot[f] = 0;
      for (int e = 0; e < HD; e++) mHist[e][f] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkAll("R1");

    // R2: startup ticks with alarms and errors are ignored
    sigLoss = 1'b1; slipEvt = 1'b1; bpvCount = 16'd100; fasCount = 16'd50;
    pulse("R2");
    pulse("R2");

    // R12: no tick, nothing moves
    allOnes = 1'b1; frameSyncLoss = 1'b1;
    repeat (5) @(negedge clk);
    checkAll("R12");

    // clean second: no-alarm code
    clearInputs();
    pulse("");
    // just below both thresholds, CRC ignored without CRC-4 mode
    bpvCount = 16'd2047; fasCount = 16'd831; crcCount = 16'd500; ebitCount = 16'd9;
    pulse("");
    // BPV threshold
    bpvCount = 16'd2048; fasCount = 16'd0;
    pulse("");
    // PCV threshold through CRC-4 mode
    crc4En = 1'b1; bpvCount = 16'd0; fasCount = 16'd400; crcCount = 16'd432; ebitCount = 16'd7;
    pulse("");
    // unavailable second with slip
    clearInputs();
    allOnes = 1'b1; slipEvt = 1'b1; bpvCount = 16'd3;
    pulse("");
    // CAS gated alarms and sync loss
    clearInputs();
    casEn = 1'b1; ts16AllOnes = 1'b1; farMfAlarm = 1'b1; casMfSyncLoss = 1'b1; frameSyncLoss = 1'b1;
    pulse("");
    // same alarms with CAS off
    casEn = 1'b0; crcMfSyncLoss = 1'b1;
    pulse("");
    clearInputs();
    bpvCount = 16'd1; fasCount = 16'd1;
    pulse("");

    // sweep
    for (int k = 0; k < 80; k++) begin
      sigLoss       = (k % 11 == 3);
      carrierLoss   = (k % 13 == 5);
      allOnes       = (k % 17 == 7);
      ts16AllOnes   = k[0];
      farMfAlarm    = k[1];
      farFrameAlarm = (k % 5 == 0);
      slipEvt       = (k % 3 == 1);
      frameSyncLoss = (k % 7 == 2);
      casMfSyncLoss = k[2];
      crcMfSyncLoss = k[3];
      crc4En        = k[4] ^ k[1];
      casEn         = k[5] ^ k[0];
      case (k % 6)
        0: bpvCount = 16'd0;
        1: bpvCount = 16'd1;
        2: bpvCount = 16'd2047;
        3: bpvCount = 16'd2048;
        4: bpvCount = 16'd5;
        default: bpvCount = 16'd40000;
      endcase
      case ((k / 2) % 6)
        0: fasCount = 16'd0;
        1: fasCount = 16'd1;
        2: fasCount = 16'd2;
        3: fasCount = 16'd831;
        4: fasCount = 16'd832;
        default: fasCount = 16'd30000;
      endcase
      case ((k / 3) % 4)
        0: crcCount = 16'd0;
        1: crcCount = 16'd3;
        2: crcCount = 16'd900;
        default: crcCount = 16'd60000;
      endcase
      ebitCount = k[0] ? 16'd7 : 16'd0;
      pulse("");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule